// File: doc/BRIEF.md
# Trigger Condition Selector with Prescalers

This block forms the global trigger decision of a detector readout system. On every clock it takes a set of already digitized physics estimators (a summed calorimeter charge, a direction-match value, a signed relative time, an auxiliary counter charge and a hit count). It compares them against programmable thresholds and windows and produces up to 32 trigger-type candidates. One type, number 31, has no detector input: a free-running pseudo-random source raises it at a programmable average rate, which gives pedestal events.

Each candidate passes through a per-type enable bit and a per-type prescaler of 32 bits. When the downstream readout is not busy, any surviving type raises a one-cycle trigger output. The surviving types are latched as the trigger pattern word. An event counter and one rate counter per type are advanced. Live-time and dead-time counters split every clock between the not-busy and busy states. A write port loads thresholds, enables and prescale factors. A read port returns the counters one cycle after the address is presented.

Top module: `trig_select`

## Requirements
- R1: After reset, trig_out is 0, trig_pattern is 0, and the event, rate, live and dead counters read 0. All types are disabled, every prescale factor is 0, and the pedestal rate is 0.
- R2: Type 0 fires when q_sum > Q_HI, dir_match < DIR_N and |t_rel| < T_N. t_rel is two's complement.
- R3: Type 1 relaxes the charge term to q_sum > Q_LO. Type 2 relaxes the direction term to dir_match < DIR_W. Type 3 relaxes the time term to |t_rel| < T_W. The other two terms stay as in type 0.
- R4: Type 10 fires when Q_LO < q_sum < Q_HI, with both bounds strict.
- R5: The remaining types are defined as follows. Type 4: q_sum > Q_LO and |t_rel| < T_N. Type 5: q_sum > Q_LO and |t_rel| < T_W. Type 6: q_sum > Q_HI, aux_q > AUX_TH and |t_rel| < T_N. Type 7: aux_q > AUX_TH. Type 8: q_sum > Q_HI. Type 9: q_sum > Q_LO. Type 11: hit_cnt >= HIT_TH. Type 12: hit_cnt >= HIT_TH and aux_q > AUX_TH. Types 13 to 30 never fire.
- R6: A type whose bit in the enable word (write address 40) is 0 never appears in trig_pattern and never causes trig_out.
- R7: The prescale factor of type i is at write address i. A factor N > 1 passes the Nth, 2Nth, ... occurrence of the enabled condition. A factor of 0 or 1 passes every occurrence. Writing a factor restarts its count.
- R8: In a cycle with busy high, no trigger is issued and no prescaler advances.
- R9: Each clock with busy low adds 1 to the live counter (read address 33). Each clock with busy high adds 1 to the dead counter (read address 34).
- R10: A trigger is decided from the inputs at one clock edge and appears at that edge. trig_out is high for that one cycle. trig_pattern holds the passed type bits until the next trigger. The event counter (read address 32) adds 1 per trigger. Rate counter i (read address i) adds 1 whenever bit i is in the pattern of an issued trigger.
- R11: Type 31 fires when a 32-bit LFSR value is below the pedestal rate word at write address 41. A rate of 0 never fires, and the all-ones rate fires on almost every clock.
- R12: Writes take effect at the clock edge where cfg_we is high. Write addresses 32 to 39 are Q_HI, Q_LO, DIR_N, DIR_W, T_N, T_W, AUX_TH and HIT_TH. rd_data shows, one edge after rd_addr is applied, the counter value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_sum | input | QW | Summed calorimeter charge |
| dir_match | input | DW | Direction-match estimator |
| t_rel | input | TW | Signed relative time |
| aux_q | input | XW | Auxiliary counter charge |
| hit_cnt | input | HW | Hit count |
| busy | input | 1 | Readout busy, blocks triggers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| rd_addr | input | AW | Counter read address |
| rd_data | output | CW | Registered counter read data |
| trig_out | output | 1 | One-cycle trigger pulse |
| trig_pattern | output | 32 | Types passed in the last trigger |

## Verification
With every type enabled and unprescaled, the charge, direction, time, auxiliary and hit inputs are swept over the values just below, at and just above each threshold. Negative and positive times are both used. This separates strict from non-strict comparisons, the narrow limits from the wide ones, and the sign handling of the time window. Single-type runs with several prescale factors, with busy cycles inserted between occurrences, show which occurrence passes and that busy cycles are not counted. The pedestal source is run with zero, half-scale and full-scale rates. Counter read-backs bracketing known numbers of busy and idle cycles show how time is split between live and dead.

// File: rtl/trig_select_pkg.sv
package trig_select_pkg;
  localparam int NTYPE    = 32;
  localparam int PED_TYPE = 31;
  // write addresses above the per-type prescale factors
  localparam int WA_QHI   = 32;
  localparam int WA_QLO   = 33;
  localparam int WA_DIRN  = 34;
  localparam int WA_DIRW  = 35;
  localparam int WA_TN    = 36;
  localparam int WA_TW    = 37;
  localparam int WA_AUX   = 38;
  localparam int WA_HIT   = 39;
  localparam int WA_EN    = 40;
  localparam int WA_PED   = 41;
  // read addresses above the per-type rate counters
  localparam int RA_EVENT = 32;
  localparam int RA_LIVE  = 33;
  localparam int RA_DEAD  = 34;
endpackage

// File: rtl/tsel_cond.sv
module tsel_cond #(
  parameter int QW = 12,
  parameter int DW = 8,
  parameter int TW = 10,
  parameter int XW = 12,
  parameter int HW = 6,
  parameter int NC = 31
) (
  input  logic [QW-1:0] q_sum,
  input  logic [DW-1:0] dir_match,
  input  logic [TW-1:0] t_rel,
  input  logic [XW-1:0] aux_q,
  input  logic [HW-1:0] hit_cnt,
  input  logic [QW-1:0] q_hi,
  input  logic [QW-1:0] q_lo,
  input  logic [DW-1:0] dir_n,
  input  logic [DW-1:0] dir_w,
  input  logic [TW-1:0] t_n,
  input  logic [TW-1:0] t_w,
  input  logic [XW-1:0] aux_th,
  input  logic [HW-1:0] hit_th,
  output logic [NC-1:0] cond
);
  logic [TW:0] t_ext, t_abs;
  logic qh, ql, dn, dw, tn, tw, ax, ht;

  always_comb begin
    t_ext = {t_rel[TW-1], t_rel};
    t_abs = t_ext[TW] ? (~t_ext + 1'b1) : t_ext;
    qh = q_sum > q_hi;
    ql = q_sum > q_lo;
    dn = dir_match < dir_n;
    dw = dir_match < dir_w;
    tn = t_abs < {1'b0, t_n};
    tw = t_abs < {1'b0, t_w};
    ax = aux_q > aux_th;
    ht = hit_cnt >= hit_th;
    cond     = '0;
    cond[0]  = qh & dn & tn;
    cond[1]  = ql & dn & tn;
    cond[2]  = qh & dw & tn;
    cond[3]  = qh & dn & tw;
    cond[4]  = ql & tn;
    cond[5]  = ql & tw;
    cond[6]  = qh & ax & tn;
    cond[7]  = ax;
    cond[8]  = qh;
    cond[9]  = ql;
    cond[10] = ql & (q_sum < q_hi);
    cond[11] = ht;
    cond[12] = ht & ax;
  end
endmodule

// File: rtl/tsel_prescale.sv
module tsel_prescale #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fac_we,
  input  logic [PW-1:0] fac_wdata,
  input  logic          hit,
  output logic          pass
);
  logic [PW-1:0] fac_q, cnt_q;
  logic          every;

  always_comb begin
    every = fac_q <= PW'(1);
    pass  = hit & (every | (cnt_q == fac_q - 1'b1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fac_q <= '0;
      cnt_q <= '0;
    end else if (fac_we) begin
      fac_q <= fac_wdata;
      cnt_q <= '0;
    end else if (hit && !every) begin
      cnt_q <= pass ? '0 : cnt_q + 1'b1;
    end
  end

  // R7: the occurrence count stays below the factor
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (fac_q > PW'(1)) |-> (cnt_q < fac_q));
endmodule

// File: rtl/tsel_ped.sv
module tsel_ped (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] rate,
  output logic        fire
);
  logic [31:0] lfsr_q;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= 32'h1;
    else     lfsr_q <= {lfsr_q[30:0], lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0]};
  end

  assign fire = lfsr_q < rate;

  // R11: the generator never locks up in the zero state
  a_r11_lfsr_live: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lfsr_q != 32'h0));
endmodule

// File: rtl/trig_select.sv
module trig_select
  import trig_select_pkg::*;
#(
  parameter int QW = 12,
  parameter int DW = 8,
  parameter int TW = 10,
  parameter int XW = 12,
  parameter int HW = 6,
  parameter int PW = 32,
  parameter int CW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [QW-1:0] q_sum,
  input  logic [DW-1:0] dir_match,
  input  logic [TW-1:0] t_rel,
  input  logic [XW-1:0] aux_q,
  input  logic [HW-1:0] hit_cnt,
  input  logic          busy,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          trig_out,
  output logic [31:0]   trig_pattern
);
  localparam int TIW = $clog2(NTYPE);

  logic [QW-1:0] q_hi, q_lo;
  logic [DW-1:0] dir_n, dir_w;
  logic [TW-1:0] t_n, t_w;
  logic [XW-1:0] aux_th;
  logic [HW-1:0] hit_th;
  logic [31:0]   en_mask, ped_rate;

  logic [NTYPE-2:0] cond_det;
  logic             ped_fire;
  logic [NTYPE-1:0] cand, pass;
  logic [CW-1:0]    rate_q [NTYPE];
  logic [CW-1:0]    event_q, live_q, dead_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      q_hi <= '0; q_lo <= '0; dir_n <= '0; dir_w <= '0;
      t_n <= '0; t_w <= '0; aux_th <= '0; hit_th <= '0;
      en_mask <= '0; ped_rate <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(WA_QHI):  q_hi     <= cfg_wdata[QW-1:0];
        AW'(WA_QLO):  q_lo     <= cfg_wdata[QW-1:0];
        AW'(WA_DIRN): dir_n    <= cfg_wdata[DW-1:0];
        AW'(WA_DIRW): dir_w    <= cfg_wdata[DW-1:0];
        AW'(WA_TN):   t_n      <= cfg_wdata[TW-1:0];
        AW'(WA_TW):   t_w      <= cfg_wdata[TW-1:0];
        AW'(WA_AUX):  aux_th   <= cfg_wdata[XW-1:0];
        AW'(WA_HIT):  hit_th   <= cfg_wdata[HW-1:0];
        AW'(WA_EN):   en_mask  <= cfg_wdata;
        AW'(WA_PED):  ped_rate <= cfg_wdata;
        default: ;
      endcase
    end
  end

  tsel_cond #(.QW(QW), .DW(DW), .TW(TW), .XW(XW), .HW(HW), .NC(NTYPE-1)) u_cond (
    .q_sum(q_sum), .dir_match(dir_match), .t_rel(t_rel), .aux_q(aux_q),
    .hit_cnt(hit_cnt), .q_hi(q_hi), .q_lo(q_lo), .dir_n(dir_n), .dir_w(dir_w),
    .t_n(t_n), .t_w(t_w), .aux_th(aux_th), .hit_th(hit_th), .cond(cond_det)
  );

  tsel_ped u_ped (.clk(clk), .rst(rst), .rate(ped_rate), .fire(ped_fire));

  assign cand = {ped_fire, cond_det} & en_mask & {NTYPE{~busy}};

  for (genvar g = 0; g < NTYPE; g++) begin : g_type
    tsel_prescale #(.PW(PW)) u_ps (
      .clk(clk), .rst(rst),
      .fac_we(cfg_we && (cfg_addr == AW'(g))),
      .fac_wdata(cfg_wdata[PW-1:0]),
      .hit(cand[g]), .pass(pass[g])
    );
    always_ff @(posedge clk) begin
      if (rst)          rate_q[g] <= '0;
      else if (pass[g]) rate_q[g] <= rate_q[g] + 1'b1;
    end
  end

  // decision, pattern and time accounting
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_out     <= 1'b0;
      trig_pattern <= '0;
      event_q      <= '0;
      live_q       <= '0;
      dead_q       <= '0;
    end else begin
      trig_out <= |pass;
      if (|pass) begin
        trig_pattern <= pass;
        event_q      <= event_q + 1'b1;
      end
      if (busy) dead_q <= dead_q + 1'b1;
      else      live_q <= live_q + 1'b1;
    end
  end

  // counter read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr < AW'(NTYPE)) rd_data <= rate_q[rd_addr[TIW-1:0]];
    else begin
      case (rd_addr)
        AW'(RA_EVENT): rd_data <= event_q;
        AW'(RA_LIVE):  rd_data <= live_q;
        AW'(RA_DEAD):  rd_data <= dead_q;
        default:       rd_data <= '0;
      endcase
    end
  end

  // R8: a busy cycle never produces a trigger
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |=> !trig_out);
  // R6: issued pattern only holds enabled types
  a_r6_mask_respected: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig_out) |-> ((trig_pattern & ~$past(en_mask)) == 32'h0));
  // R10: event counter moves with the trigger pulse and only then
  a_r10_event_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && trig_out) |-> (event_q == $past(event_q) + 1'b1));
  a_r10_event_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !trig_out) |-> $stable(event_q));
  // R9: every clock lands in exactly one of live or dead
  a_r9_time_split: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((live_q + dead_q) == ($past(live_q) + $past(dead_q) + 1'b1)));
endmodule

// File: tb/trig_select_test.sv
module trig_select_test;
  localparam int CLK_PERIOD = 10;
  localparam int QH = 200, QL = 100, DN = 20, DWI = 60, TN = 10, TWI = 30, AXT = 50, HT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] q_sum = '0;
  logic [7:0]  dir_match = '0;
  logic [9:0]  t_rel = '0;
  logic [11:0] aux_q = '0;
  logic [5:0]  hit_cnt = '0;
  logic        busy = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        trig_out;
  logic [31:0] trig_pattern;

  int errors = 0, checks = 0;
  bit done = 0;

  trig_select uut (
    .clk(clk), .rst(rst), .q_sum(q_sum), .dir_match(dir_match), .t_rel(t_rel),
    .aux_q(aux_q), .hit_cnt(hit_cnt), .busy(busy), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .trig_out(trig_out), .trig_pattern(trig_pattern)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(posedge clk); #1; cfg_we = 1'b0;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic idle_in;
    @(negedge clk); q_sum = '0; dir_match = '0; t_rel = '0; aux_q = '0; hit_cnt = '0; busy = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); rd_addr = 6'(a);
    @(posedge clk); #1; v = rd_data;
  endtask

  function automatic logic [31:0] model(input int q, input int d, input int t, input int ax, input int h);
    logic [31:0] m = '0;
    int ta = (t < 0) ? -t : t;
    bit qh = q > QH, ql = q > QL, dn = d < DN, dw = d < DWI, tn = ta < TN, tw = ta < TWI;
    bit a = ax > AXT, hh = h >= HT;
    m[0] = qh && dn && tn;  m[1] = ql && dn && tn;  m[2] = qh && dw && tn;
    m[3] = qh && dn && tw;  m[4] = ql && tn;        m[5] = ql && tw;
    m[6] = qh && a && tn;   m[7] = a;               m[8] = qh;
    m[9] = ql;              m[10] = ql && q < QH;   m[11] = hh;
    m[12] = hh && a;
    return m;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v0, v1, ep;
    int qv[6] = '{99, 100, 101, 199, 200, 201};
    int dv[4] = '{19, 20, 59, 60};
    int tv[8] = '{-30, -10, -9, 0, 9, 10, 29, 30};
    int av[2] = '{50, 51};
    int hv[2] = '{3, 4};
    int n_ev, n_r0, n_r10, cnt;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    step;
    // R1 reset state
    chk("R1 trig_out", {31'b0, trig_out}, 32'h0);
    chk("R1 pattern", trig_pattern, 32'h0);
    rd(32, v); chk("R1 event", v, 0);
    rd(0, v);  chk("R1 rate0", v, 0);
    // R6 nothing enabled: a strong event gives no trigger
    @(negedge clk); q_sum = 12'd300;
    step; chk("R6 disabled no trig", {31'b0, trig_out}, 32'h0);
    idle_in;

    // R12 configuration
    wr(32, QH); wr(33, QL); wr(34, DN); wr(35, DWI);
    wr(36, TN); wr(37, TWI); wr(38, AXT); wr(39, HT);
    wr(40, 32'hFFFF_FFFF); wr(41, 0);

    // R2 R3 R4 R5 sweep around every boundary
    n_ev = 0; n_r0 = 0; n_r10 = 0;
    foreach (qv[i]) foreach (dv[j]) foreach (tv[k]) foreach (av[a]) foreach (hv[b]) begin
      @(negedge clk);
      q_sum = 12'(qv[i]); dir_match = 8'(dv[j]); t_rel = 10'(tv[k]);
      aux_q = 12'(av[a]); hit_cnt = 6'(hv[b]);
      ep = model(qv[i], dv[j], tv[k], av[a], hv[b]);
      step;
      chk("R2 R3 R4 R5 trig_out", {31'b0, trig_out}, {31'b0, |ep});
      if (|ep) begin
        chk("R2 R3 R4 R5 pattern", trig_pattern, ep);
        n_ev++;
        if (ep[0]) n_r0++;
        if (ep[10]) n_r10++;
      end
    end
    idle_in;
    rd(32, v); chk("R10 event count", v, 32'(n_ev));
    rd(0, v);  chk("R10 rate type0", v, 32'(n_r0));
    rd(10, v); chk("R10 rate type10", v, 32'(n_r10));

    // R10 pattern held after a trigger, trig_out one cycle
    step; chk("R10 pulse ends", {31'b0, trig_out}, 32'h0);

    // R7 R8 prescale by 3 on type 9, busy cycles ignored
    wr(40, 32'h0000_0200); wr(9, 3);
    for (int n = 1; n <= 9; n++) begin
      @(negedge clk); q_sum = 12'd150; busy = 1'b1;
      step; chk("R8 busy no trig", {31'b0, trig_out}, 32'h0);
      @(negedge clk); busy = 1'b0;
      step;
      chk("R7 factor 3", {31'b0, trig_out}, {31'b0, (n % 3) == 0});
      if (n % 3 == 0) chk("R7 pattern", trig_pattern, 32'h0000_0200);
    end
    wr(9, 0);
    for (int n = 0; n < 3; n++) begin
      step; chk("R7 factor 0 every", {31'b0, trig_out}, 32'h1);
    end
    wr(9, 1);
    step; chk("R7 factor 1 every", {31'b0, trig_out}, 32'h1);
    idle_in;

    // R9 dead and live accounting
    @(negedge clk); rd_addr = 6'd34; step; v0 = rd_data;
    @(negedge clk); busy = 1'b1;
    repeat (7) step;
    @(negedge clk); busy = 1'b0;
    step; v1 = rd_data;
    chk("R9 dead +7", v1 - v0, 7);
    @(negedge clk); rd_addr = 6'd33; step; v0 = rd_data;
    repeat (5) step;
    v1 = rd_data;
    chk("R9 live +5", v1 - v0, 5);

    // R11 pedestal source
    wr(40, 32'h8000_0000); wr(41, 0);
    cnt = 0;
    for (int n = 0; n < 200; n++) begin step; if (trig_out) cnt++; end
    chk("R11 rate zero", 32'(cnt), 0);
    wr(41, 32'h8000_0000);
    cnt = 0;
    for (int n = 0; n < 200; n++) begin step; if (trig_out) cnt++; end
    chk("R11 half rate in range", {31'b0, cnt > 40 && cnt < 160}, 32'h1);
    chk("R11 pattern bit31", trig_pattern, 32'h8000_0000);
    wr(41, 32'hFFFF_FFFF);
    cnt = 0;
    for (int n = 0; n < 200; n++) begin step; if (trig_out) cnt++; end
    chk("R11 full rate", {31'b0, cnt >= 195}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule